// File: doc/BRIEF.md
# Significand Rounding Unit

This block takes a sign-magnitude significand that still carries a few low-order bits beyond its final width, and rounds it down to the kept width. The value arrives as a kept field, a small field of guard bits just below the lowest kept bit, and a single sticky bit. The sticky bit is the OR of everything further down. A 2-bit mode input picks one of four rounding rules. The sign matters only for the two directed modes.

The rounder does not adjust the exponent and does not normalise. When an increment overflows the kept field, the carry flag tells the caller to renormalise. The inexact flag reports that some information was discarded. The datapath is combinational. A parameter adds one output register stage, which is reset to zero.

Top module: `mant_rounder`

## Requirements
- R1: `mode_i` selects the rule: 2'b00 nearest with ties to even, 2'b01 toward zero, 2'b10 toward +infinity, 2'b11 toward -infinity. Code 2'b00 is the default that a caller applies out of reset.
- R2: `inexact_o` is 1 exactly when any bit of `grd_i` or `sticky_i` is 1.
- R3: In nearest mode, the increment decision depends on the discarded part. The top guard bit weighs one half of the lowest kept bit, the lower guard bits weigh less, and the sticky bit lies below all of them. The significand is incremented when the discarded part is above one half. It is left unchanged when the discarded part is below one half.
- R4: In nearest mode, a tie means the guard field is 1 followed by zeros and sticky is 0. A tie increments only when bit 0 of `sig_i` is 1.
- R5: Toward-zero mode never increments, whatever the sign.
- R6: Toward +infinity increments a positive (`sign_i`=0) inexact value. It never increments a negative one.
- R7: Toward -infinity increments a negative (`sign_i`=1) inexact value. It never increments a positive one.
- R8: An exact input, with all guard and sticky bits zero, leaves `sig_o` equal to `sig_i` with `carry_o` 0 in every mode.
- R9: An increment of an all-ones significand gives `sig_o` all zeros with `carry_o` 1. `carry_o` is never 1 with a nonzero `sig_o`.
- R10: With `REG_OUT`=1, outputs follow the inputs one clock edge later. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| sig_i | input | MANT_W | Kept significand bits |
| grd_i | input | GRD_W | Guard bits, MSB is the half-weight bit |
| sticky_i | input | 1 | OR of all bits below the guard field |
| mode_i | input | 2 | Rounding rule select |
| sig_o | output | MANT_W | Rounded significand |
| carry_o | output | 1 | Increment overflowed the kept field |
| inexact_o | output | 1 | Discarded bits were nonzero |

## Verification
The bench targets exact ties with both parities of the lowest kept bit. A design that rounded ties up would turn an even result odd. A design that ignored the sticky bit would leave a value just above half unrounded. Each directed mode is tried with both signs: a design with the sign test inverted would move negative values the wrong way. The bench also covers an all-ones significand that overflows, where a wrong design would wrap without raising the carry. Exact inputs are checked as well, since wrongly bumping them would corrupt values that need no rounding.

// File: rtl/mrnd_pkg.sv
`timescale 1ns/1ps
package mrnd_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_ZERO      = 2'b01,
    RM_POS       = 2'b10,
    RM_NEG       = 2'b11
  } rmode_e;

  // Decide whether the kept magnitude must grow by one unit.
  function automatic logic bump_needed(
    input rmode_e m,
    input logic   neg,
    input logic   lsb,
    input logic   half,
    input logic   below,
    input logic   lost
  );
    logic r;
    unique case (m)
      RM_NEAR_EVEN: r = half & (below | lsb);
      RM_ZERO:      r = 1'b0;
      RM_POS:       r = lost & ~neg;
      RM_NEG:       r = lost & neg;
      default:      r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mrnd_classify.sv
`timescale 1ns/1ps
module mrnd_classify #(
  parameter int GRD_W = 3
) (
  input  logic [GRD_W-1:0] grd_i,
  input  logic             sticky_i,
  output logic             half_o,
  output logic             below_o,
  output logic             lost_o
);
  assign half_o = grd_i[GRD_W-1];
  assign lost_o = (|grd_i) | sticky_i;

  generate
    if (GRD_W > 1) begin : g_multi
      assign below_o = (|grd_i[GRD_W-2:0]) | sticky_i;
    end else begin : g_single
      assign below_o = sticky_i;
    end
  endgenerate
endmodule

// File: rtl/mrnd_decide.sv
`timescale 1ns/1ps
module mrnd_decide
  import mrnd_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       sign_i,
  input  logic       lsb_i,
  input  logic       half_i,
  input  logic       below_i,
  input  logic       lost_i,
  output logic       inc_o
);
  rmode_e mode_e;
  assign mode_e = rmode_e'(mode_i);
  assign inc_o  = bump_needed(mode_e, sign_i, lsb_i, half_i, below_i, lost_i);
endmodule

// File: rtl/mrnd_incr.sv
`timescale 1ns/1ps
module mrnd_incr #(
  parameter int MANT_W = 8
) (
  input  logic [MANT_W-1:0] sig_i,
  input  logic              inc_i,
  output logic [MANT_W-1:0] sum_o,
  output logic              carry_o
);
  localparam int SUM_W = MANT_W + 1;
  logic [SUM_W-1:0] wide;
  assign wide    = {1'b0, sig_i} + {{MANT_W{1'b0}}, inc_i};
  assign sum_o   = wide[MANT_W-1:0];
  assign carry_o = wide[SUM_W-1];
endmodule

// File: rtl/mant_rounder.sv
`timescale 1ns/1ps
module mant_rounder #(
  parameter int MANT_W  = 8,
  parameter int GRD_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sign_i,
  input  logic [MANT_W-1:0] sig_i,
  input  logic [GRD_W-1:0]  grd_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-1:0] sig_o,
  output logic              carry_o,
  output logic              inexact_o
);
  // Named internal events, also observed by the checker.
  logic              half_w;
  logic              below_w;
  logic              lost_w;
  logic              inc_w;
  logic [MANT_W-1:0] sum_w;
  logic              cy_w;

  mrnd_classify #(.GRD_W(GRD_W)) u_cls (
    .grd_i    (grd_i),
    .sticky_i (sticky_i),
    .half_o   (half_w),
    .below_o  (below_w),
    .lost_o   (lost_w)
  );

  mrnd_decide u_dec (
    .mode_i  (mode_i),
    .sign_i  (sign_i),
    .lsb_i   (sig_i[0]),
    .half_i  (half_w),
    .below_i (below_w),
    .lost_i  (lost_w),
    .inc_o   (inc_w)
  );

  mrnd_incr #(.MANT_W(MANT_W)) u_inc (
    .sig_i   (sig_i),
    .inc_i   (inc_w),
    .sum_o   (sum_w),
    .carry_o (cy_w)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sig_o     <= '0;
          carry_o   <= 1'b0;
          inexact_o <= 1'b0;
        end else begin
          sig_o     <= sum_w;
          carry_o   <= cy_w;
          inexact_o <= lost_w;
        end
      end
    end else begin : g_comb
      assign sig_o     = sum_w;
      assign carry_o   = cy_w;
      assign inexact_o = lost_w;
    end
  endgenerate
endmodule

// File: rtl/mant_rounder_chk.sv
`timescale 1ns/1ps
module mant_rounder_chk #(
  parameter int MANT_W  = 8,
  parameter int GRD_W   = 3,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sign_i,
  input logic [MANT_W-1:0] sig_i,
  input logic [GRD_W-1:0]  grd_i,
  input logic              sticky_i,
  input logic [1:0]        mode_i,
  input logic              inc_w,
  input logic [MANT_W-1:0] sig_o,
  input logic              carry_o,
  input logic              inexact_o
);
  localparam logic [GRD_W-1:0] TIE_PAT = {1'b1, {(GRD_W-1){1'b0}}};

  // R5
  zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b01) |-> !inc_w);

  // R6
  pos_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b10 && sign_i) |-> !inc_w);

  // R7
  neg_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b11 && !sign_i) |-> !inc_w);

  // R8
  exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grd_i == '0 && !sticky_i) |-> !inc_w);

  // R4
  tie_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && grd_i == TIE_PAT && !sticky_i && !sig_i[0]) |-> !inc_w);

  // R9
  carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_o |-> (sig_o == '0));

  generate
    if (REG_OUT) begin : g_lat
      // R2
      inexact_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (inexact_o == ($past(|grd_i) | $past(sticky_i))));
    end else begin : g_now
      // R2
      inexact_comb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inexact_o == ((|grd_i) | sticky_i));
    end
  endgenerate
endmodule

bind mant_rounder mant_rounder_chk #(
  .MANT_W (MANT_W),
  .GRD_W  (GRD_W),
  .REG_OUT(REG_OUT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sign_i    (sign_i),
  .sig_i     (sig_i),
  .grd_i     (grd_i),
  .sticky_i  (sticky_i),
  .mode_i    (mode_i),
  .inc_w     (inc_w),
  .sig_o     (sig_o),
  .carry_o   (carry_o),
  .inexact_o (inexact_o)
);

// File: tb/tb_mant_rounder.sv
`timescale 1ns/1ps
module tb_mant_rounder;
  localparam int MW = 8;
  localparam int GW = 3;
  localparam int NV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sign_i = 1'b0;
  logic [MW-1:0] sig_i = '0;
  logic [GW-1:0] grd_i = '0;
  logic          sticky_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [MW-1:0] sig_o;
  logic          carry_o;
  logic          inexact_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mant_rounder #(.MANT_W(MW), .GRD_W(GW), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .sign_i(sign_i), .sig_i(sig_i), .grd_i(grd_i),
    .sticky_i(sticky_i), .mode_i(mode_i), .sig_o(sig_o), .carry_o(carry_o),
    .inexact_o(inexact_o)
  );

  // {sign, mode, sig, guard, sticky, exp_sig, exp_carry, exp_inexact}
  localparam logic [24:0] VEC [0:NV-1] = '{
    {1'b0, 2'b00, 8'h05, 3'b100, 1'b0, 8'h06, 1'b0, 1'b1}, // R4 tie, odd -> up
    {1'b0, 2'b00, 8'h04, 3'b100, 1'b0, 8'h04, 1'b0, 1'b1}, // R4 tie, even -> stay
    {1'b0, 2'b00, 8'h04, 3'b100, 1'b1, 8'h05, 1'b0, 1'b1}, // R3 sticky lifts above half
    {1'b0, 2'b00, 8'h04, 3'b011, 1'b1, 8'h04, 1'b0, 1'b1}, // R3 below half
    {1'b0, 2'b00, 8'h07, 3'b000, 1'b0, 8'h07, 1'b0, 1'b0}, // R8 exact
    {1'b0, 2'b01, 8'h07, 3'b111, 1'b1, 8'h07, 1'b0, 1'b1}, // R5 chop
    {1'b0, 2'b10, 8'h10, 3'b001, 1'b0, 8'h11, 1'b0, 1'b1}, // R6 positive up
    {1'b1, 2'b10, 8'h10, 3'b001, 1'b0, 8'h10, 1'b0, 1'b1}, // R6 negative chop
    {1'b1, 2'b11, 8'h10, 3'b000, 1'b1, 8'h11, 1'b0, 1'b1}, // R7 negative grows
    {1'b0, 2'b11, 8'h10, 3'b110, 1'b0, 8'h10, 1'b0, 1'b1}, // R7 positive chop
    {1'b0, 2'b00, 8'hFF, 3'b110, 1'b0, 8'h00, 1'b1, 1'b1}, // R9 overflow
    {1'b0, 2'b10, 8'hFF, 3'b000, 1'b0, 8'hFF, 1'b0, 1'b0}  // R8 exact all-ones
  };
  localparam int VREQ [0:NV-1] = '{4, 4, 3, 3, 8, 5, 6, 6, 7, 7, 9, 8};

  task automatic compare(input int req, input logic [MW-1:0] es,
                         input logic ec, input logic ei);
    n_run++;
    if (sig_o !== es || carry_o !== ec || inexact_o !== ei) begin
      n_fail++;
      $display("FAIL R%0d got sig=%h c=%b x=%b exp sig=%h c=%b x=%b",
               req, sig_o, carry_o, inexact_o, es, ec, ei);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] m, input logic [MW-1:0] v,
                       input logic [GW-1:0] g, input logic st);
    @(negedge clk);
    sign_i = s; mode_i = m; sig_i = v; grd_i = g; sticky_i = st;
  endtask

  // Independent model: discarded part as a fraction of 2^(GW+1).
  function automatic logic model_up(input logic s, input logic [1:0] m,
                                    input logic lsb, input int frac);
    int halfv = 1 << GW;
    case (m)
      2'b00:   return (frac > halfv) || (frac == halfv && lsb);
      2'b10:   return (frac != 0) && !s;
      2'b11:   return (frac != 0) && s;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R10 reset: outputs zero even with live inputs
    sig_i = 8'hFF; grd_i = 3'b111; sticky_i = 1'b1;
    repeat (3) @(negedge clk);
    compare(10, 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24], VEC[i][23:22], VEC[i][21:14], VEC[i][13:11], VEC[i][10]);
      @(negedge clk);
      compare(VREQ[i], VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R10 latency: new input is not visible before the next edge
    drive(1'b0, 2'b00, 8'h20, 3'b000, 1'b0);
    @(negedge clk);
    compare(10, 8'h20, 1'b0, 1'b0);
    sig_i = 8'h33; grd_i = 3'b111;
    #2;
    compare(10, 8'h20, 1'b0, 1'b0);
    @(negedge clk);
    compare(10, 8'h34, 1'b0, 1'b1);

    // R1 R2 R3 sweep of all modes, signs, lsb parities and discarded patterns
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        for (int l = 0; l < 2; l++)
          for (int f = 0; f < (1 << (GW + 1)); f++) begin
            logic [MW-1:0] base;
            logic          up;
            base = 8'h4A | MW'(l);
            up   = model_up(s[0], m[1:0], l[0], f);
            drive(s[0], m[1:0], base, f[GW:1], f[0]);
            @(negedge clk);
            compare(1, base + MW'(up), 1'b0, (f != 0));
          end

    // R9 overflow under toward -infinity with a negative value
    drive(1'b1, 2'b11, 8'hFF, 3'b000, 1'b1);
    @(negedge clk);
    compare(9, 8'h00, 1'b1, 1'b1);

    // R10 reset mid-run clears registered outputs
    rst_n = 1'b0;
    #1;
    compare(10, 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule